// File: doc/BRIEF.md
# Serial Game Controller Readout

This block gives a processor two serial controller ports at two neighbouring bus addresses. Each port holds a 24-bit snapshot of button and expansion states. The processor reads a port one bit at a time. Every read returns the snapshot bit selected by that port's position counter, then moves the counter on by one. The counter runs from 0 to 23 and then starts again at 0.

A control bit at the first port's address restarts both readouts. Software writes bit 0 low and then high. On the low-to-high transition, both position counters return to 0. On the same edge, both parallel state inputs are captured into the snapshots, so one pass over the 24 positions always sees a single consistent set of states. The block remembers the last control value written, and it acts on that value only when bit 0 goes from 0 to 1.

Read data is registered. It appears on the data output one clock after the read strobe and stays there until the next read.

Top module: `serial_pad_reader`

## Requirements
- R1: Port 0 is read at address offset 0x16 and port 1 at offset 0x17. A read of one port advances only that port's position counter.
- R2: A port read returns, on the clock after the read strobe, a byte with bit 0 equal to the snapshot bit at the current position, bit 6 equal to 1 and every other bit 0. The byte holds until the next read.
- R3: Snapshot position 0 holds state input bit 0. After each read the position increments, and after position 23 it returns to 0.
- R4: A write to offset 0x16 with data bit 0 = 1, when the stored control bit is 0, sets both positions to 0 and captures both state inputs into the snapshots.
- R5: A write to offset 0x16 when the stored control bit is already 1, or with data bit 0 = 0, leaves positions and snapshots unchanged. It only updates the stored control bit.
- R6: Writes to any address other than 0x16, including 0x17, change neither the stored control bit nor the positions.
- R7: A read at any other address returns 0x00 on the next clock and leaves both positions unchanged.
- R8: Reset clears both positions, both snapshots, the stored control bit and the read data register.
- R9: Changes on the state inputs after a capture do not appear in read data until the next 0-to-1 control transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Bus address offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad0_state | input | PAD_BITS (24) | Parallel state of controller 0 |
| pad1_state | input | PAD_BITS (24) | Parallel state of controller 1 |

## Verification
A wrong position counter shows up on the very next read of that port: the returned bit comes from the wrong snapshot position. The bench therefore compares every single read against a model. A bad wrap shows up at the twenty-fifth read after a capture. A missed or spurious capture shows up on the first read after the control write, either as a position that did not restart or as bits from the live inputs instead of the snapshot. A wrongly updated stored control bit stays hidden until the next write of 1: that write then fails to restart the readout, or restarts it when it should not.

// File: rtl/pad_pkg.sv
package pad_pkg;

    localparam int PAD_PORTS    = 2;
    localparam int DATA_W       = 8;
    localparam int OPEN_BUS_BIT = 6;

    typedef struct packed {
        logic [PAD_PORTS-1:0] rd_hit;
        logic                 rd_miss;
        logic                 wr_ctrl;
        logic [DATA_W-1:0]    wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] read_byte(input logic serial_bit);
        logic [DATA_W-1:0] r;
        r               = '0;
        r[OPEN_BUS_BIT] = 1'b1;
        r[0]            = serial_bit;
        return r;
    endfunction

endpackage

// File: rtl/pad_bus_decode.sv
module pad_bus_decode
    import pad_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter int unsigned BASE_OFS = 'h16
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_req_t          req
);
    logic [PAD_PORTS-1:0] hit;

    for (genvar p = 0; p < PAD_PORTS; p++) begin : g_hit
        assign hit[p] = (bus_addr == ADDR_W'(BASE_OFS + p));
    end

    always_comb begin
        req.rd_hit  = hit & {PAD_PORTS{bus_rd}};
        req.rd_miss = bus_rd && (hit == '0);
        req.wr_ctrl = bus_wr && hit[0];
        req.wdata   = bus_wdata;
    end
endmodule

// File: rtl/pad_strobe_ctrl.sv
module pad_strobe_ctrl
    import pad_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     strobe_q,
    output logic     strobe_rise
);
    assign strobe_rise = req.wr_ctrl && req.wdata[0] && !strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else if (req.wr_ctrl) begin
            strobe_q <= req.wdata[0];
        end
    end
endmodule

// File: rtl/pad_shift_port.sv
module pad_shift_port #(
    parameter int PAD_BITS = 24,
    parameter int IDX_W    = (PAD_BITS > 1) ? $clog2(PAD_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                adv,
    input  logic [PAD_BITS-1:0] state_in,
    output logic                bit_out,
    output logic [IDX_W-1:0]    idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PAD_BITS - 1);

    logic [PAD_BITS-1:0] snap;

    assign bit_out = snap[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
            idx  <= '0;
        end else if (load) begin
            snap <= state_in;
            idx  <= '0;
        end else if (adv) begin
            idx  <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/serial_pad_reader.sv
module serial_pad_reader
    import pad_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter int          PAD_BITS = 24,
    parameter int unsigned BASE_OFS = 'h16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [PAD_BITS-1:0] pad0_state,
    input  logic [PAD_BITS-1:0] pad1_state
);
    localparam int IDX_W = (PAD_BITS > 1) ? $clog2(PAD_BITS) : 1;

    bus_req_t            req;
    logic                strobe_q;
    logic                strobe_rise;
    logic [PAD_BITS-1:0] state_arr [PAD_PORTS];
    logic [PAD_PORTS-1:0] port_bit;
    logic [IDX_W-1:0]    port_idx  [PAD_PORTS];
    logic                sel_bit;

    assign state_arr[0] = pad0_state;
    assign state_arr[1] = pad1_state;

    pad_bus_decode #(.ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .req      (req)
    );

    pad_strobe_ctrl u_strobe (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .strobe_q   (strobe_q),
        .strobe_rise(strobe_rise)
    );

    for (genvar p = 0; p < PAD_PORTS; p++) begin : g_port
        pad_shift_port #(.PAD_BITS(PAD_BITS), .IDX_W(IDX_W)) u_port (
            .clk     (clk),
            .rst     (rst),
            .load    (strobe_rise),
            .adv     (req.rd_hit[p]),
            .state_in(state_arr[p]),
            .bit_out (port_bit[p]),
            .idx     (port_idx[p])
        );
    end

    always_comb begin
        sel_bit = 1'b0;
        for (int p = 0; p < PAD_PORTS; p++) begin
            if (req.rd_hit[p]) sel_bit = port_bit[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= req.rd_miss ? '0 : read_byte(sel_bit);
        end
    end
endmodule

// File: rtl/pad_reader_checker.sv
module pad_reader_checker #(
    parameter int          ADDR_W   = 5,
    parameter int          IDX_W    = 5,
    parameter int          PAD_BITS = 24,
    parameter int unsigned BASE_OFS = 'h16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [IDX_W-1:0]  idx0,
    input logic [IDX_W-1:0]  idx1,
    input logic              strobe_q
);
    localparam logic [ADDR_W-1:0] A0   = ADDR_W'(BASE_OFS);
    localparam logic [ADDR_W-1:0] A1   = ADDR_W'(BASE_OFS + 1);
    localparam logic [IDX_W-1:0]  LAST = IDX_W'(PAD_BITS - 1);

    logic rise;
    assign rise = bus_wr && bus_addr == A0 && bus_wdata[0] && !strobe_q;

    assert_read_format_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A0 || bus_addr == A1)) |=>
            (bus_rdata[6] && bus_rdata[7] == 1'b0 && bus_rdata[5:1] == '0));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A0 && idx0 == LAST && !rise) |=> (idx0 == '0));

    assert_rise_clears_R4: assert property (@(posedge clk) disable iff (rst)
        rise |=> (idx0 == '0 && idx1 == '0 && strobe_q));

    assert_no_rise_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A0 && strobe_q && !bus_rd) |=>
            ($stable(idx0) && $stable(idx1)));

    assert_other_write_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != A0) |=> $stable(strobe_q));

    assert_other_read_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr != A0 && bus_addr != A1 && !bus_wr) |=>
            ($stable(idx0) && $stable(idx1) && bus_rdata == 8'h00));
endmodule

bind serial_pad_reader pad_reader_checker #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .PAD_BITS(PAD_BITS),
    .BASE_OFS(BASE_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .idx0     (port_idx[0]),
    .idx1     (port_idx[1]),
    .strobe_q (strobe_q)
);

// File: tb/test_serial_pad_reader.sv
module test_serial_pad_reader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] pad0_state = '0;
    logic [23:0] pad1_state = '0;

    always #5 clk = ~clk;

    serial_pad_reader i_serial_pad_reader (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad0_state(pad0_state), .pad1_state(pad1_state)
    );

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    // model
    int          m_idx [2];
    logic        m_strobe;
    logic [23:0] m_snap [2];

    task automatic model_reset();
        m_idx[0] = 0; m_idx[1] = 0; m_strobe = 1'b0;
        m_snap[0] = '0; m_snap[1] = '0;
    endtask

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        if (a == 5'h16) begin
            if (d[0] && !m_strobe) begin
                m_idx[0] = 0; m_idx[1] = 0;
                m_snap[0] = pad0_state; m_snap[1] = pad1_state;
            end
            m_strobe = d[0];
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        if (a == 5'h16 || a == 5'h17) begin
            int p;
            p = (a == 5'h16) ? 0 : 1;
            e = 8'h40 | {7'b0, m_snap[p][m_idx[p]]};
            m_idx[p] = (m_idx[p] == 23) ? 0 : m_idx[p] + 1;
        end else begin
            e = 8'h00;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor
    logic rd_d = 1'b0;
    always @(posedge clk) rd_d <= bus_rd && !rst;

    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: actual %02h expected none", bus_rdata);
            end else begin
                check8(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check8(bus_rdata, 8'h00, "R8 reset rdata");
        bus_read(5'h16, "R8 empty snapshot");

        // capture and full sweep with wrap
        pad0_state = 24'hC3A55A;
        pad1_state = 24'h0F1E2D;
        bus_write(5'h16, 8'h01);
        for (int i = 0; i < 26; i++) bus_read(5'h16, "R3 port0 sweep/wrap");
        for (int i = 0; i < 5; i++)  bus_read(5'h17, "R1 port1 independent");

        // live input change is not visible
        pad0_state = 24'hFFFFFF;
        pad1_state = 24'h000000;
        for (int i = 0; i < 4; i++) bus_read(5'h17, "R9 snapshot held");

        // control already high: no restart
        bus_write(5'h16, 8'hFF);
        for (int i = 0; i < 3; i++) bus_read(5'h16, "R5 no restart");

        // writes elsewhere ignored, other reads ignored
        bus_write(5'h17, 8'h00);
        bus_write(5'h03, 8'h00);
        bus_write(5'h16, 8'h01);
        bus_read(5'h16, "R6 still no edge");
        bus_read(5'h15, "R7 other read zero");
        bus_read(5'h00, "R7 other read zero");
        bus_read(5'h16, "R7 index kept");
        bus_read(5'h17, "R7 index kept");

        // falling then rising restarts and recaptures
        bus_write(5'h16, 8'h00);
        bus_read(5'h16, "R5 low write no restart");
        bus_write(5'h16, 8'h01);
        for (int i = 0; i < 3; i++) bus_read(5'h16, "R4 restart port0");
        for (int i = 0; i < 3; i++) bus_read(5'h17, "R4 restart port1");

        // reset mid-run
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        model_reset();
        rst = 1'b0;
        check8(bus_rdata, 8'h00, "R8 reset rdata again");
        bus_read(5'h17, "R8 cleared snapshot");
        bus_write(5'h16, 8'h01);
        bus_read(5'h16, "R8 strobe cleared so edge seen");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule